// File: doc/BRIEF.md
# Echoed-Clock Serial ADC Host Controller

This block is the host-side sequencer for a fast serial analog-to-digital converter that returns its conversion result over a clock-forwarded link. The controller drives a conversion pulse at a programmable period and pulse width. It then waits a programmable MSB-ready delay and bursts exactly sixteen read clocks. The bits are captured on the rising edge of the converter's echoed copy of that read clock, not on the system clock. The converter changes its data on the falling edge of the echo, so capture on the rising edge has half a read-clock period of margin.

Each captured word crosses from the echo domain to the system clock with a toggle synchroniser. It is then offered to user logic on a valid/ready output. Back-pressure never stalls the converter, because conversions are periodic and cannot wait. While `res_valid` is high and `res_ready` is low, the word is held. A newer result that arrives in that time replaces the held word, so the latest sample always wins. With `res_ready` tied high, `res_valid` is a one-cycle strobe per word.

The conversion timing is checked against the read window at the start of every conversion. A configuration that would let the burst finish past the readout deadline, or run into the next burst, raises an overrun flag. In that case the burst is not issued at all, so no word is produced.

Top module: `ecadc_host`

## Requirements
- R1: After reset, and until `run` is first seen high, `adc_cnv`, `adc_sclk`, `res_valid` and `err_overrun` are all low.
- R2: Each conversion pulse is high for exactly W cycles. W is `cfg_pulse_w`, with 0 treated as 1 and values above `CNV_MAX_HI` (default 16) clamped to `CNV_MAX_HI`.
- R3: While `run` is high, successive rising edges of `adc_cnv` are exactly P cycles apart, where P is `cfg_period` raised to at least W+1. When `run` falls, the current period completes and no further pulse is issued.
- R4: In a conversion that is not overrun, the first rising edge of `adc_sclk` comes exactly `cfg_msb_dly`+1 cycles after the rising edge of `adc_cnv`. It never comes earlier than the MSB-ready delay.
- R5: A non-overrun conversion produces exactly NBITS (16) rising edges of `adc_sclk`. Each high phase and each low phase inside the burst lasts H cycles, where H is `cfg_half_div` with 0 treated as 1. The read clock is low between bursts.
- R6: Bits are taken on rising edges of `adc_echo`, most significant first. The delivered `res_data` equals the sixteen bits the converter shifted out, including the first conversion after reset.
- R7: `res_valid` stays high with `res_data` stable until `res_ready` is high. With `res_ready` high, `res_valid` lasts one cycle per word. A word that arrives while an unaccepted one is held replaces it.
- R8: At each conversion start, `err_overrun` is set to whether (D+1+2·NBITS·H > P+`DEADLINE_CYC`) or (2·NBITS·H ≥ P) or (D ≥ P), where D is `cfg_msb_dly` and `DEADLINE_CYC` defaults to 24. When it is set, that conversion emits no read clocks and produces no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Free-run enable; conversions repeat while high |
| cfg_pulse_w | input | CNT_W | Conversion pulse width in cycles |
| cfg_msb_dly | input | CNT_W | MSB-ready delay in cycles from pulse rise |
| cfg_period | input | CNT_W | Conversion period in cycles |
| cfg_half_div | input | DIV_W | Read-clock half period in cycles |
| adc_cnv | output | 1 | Conversion start pulse to the converter |
| adc_sclk | output | 1 | Gated read clock to the converter |
| adc_echo | input | 1 | Echoed read clock from the converter |
| adc_sdata | input | 1 | Serial data from the converter |
| res_data | output | NBITS | Assembled conversion result |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted by user logic |
| err_overrun | output | 1 | Timing of the latest conversion overruns the read window |

## Verification
The bench uses a configuration whose burst runs past the next conversion pulse. A controller that bound readout to its own period, or a converter model that lost the word, would then deliver a wrong or missing value. Zero and oversized pulse widths, a zero read-clock divisor and a period below the pulse width probe the clamping rules. A miscounted clamp shows up as a wrong pulse length, a wrong half period or a wrong pulse spacing. One overrun configuration must produce no read clocks and no word, and the next good run must clear the flag. A sticky or ignored flag would either keep suppressing results or let a late burst through. Holding `res_ready` low across two conversions checks that the newest word is kept and then offered once. An off-by-one in bit count or capture edge would corrupt every scoreboard comparison.

// File: rtl/ecadc_pkg.sv
`timescale 1ns/1ps
package ecadc_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/ecadc_seq.sv
`timescale 1ns/1ps
module ecadc_seq
  import ecadc_pkg::*;
#(
  parameter int NBITS        = 16,
  parameter int CNT_W        = 16,
  parameter int DIV_W        = 8,
  parameter int CNV_MAX_HI   = 16,
  parameter int DEADLINE_CYC = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cfg_pulse_w,
  input  logic [CNT_W-1:0] cfg_msb_dly,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [DIV_W-1:0] cfg_half_div,
  output logic             cnv,
  output logic             go,
  output logic             ovr,
  output logic [DIV_W-1:0] half_o
);

  localparam int EXT_W = CNT_W + DIV_W + $clog2(2 * NBITS) + 2;
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAXHI_C = CNT_W'(CNV_MAX_HI);
  localparam logic [DIV_W-1:0] ONE_D   = DIV_W'(1);
  localparam logic [EXT_W-1:0] ONE_E   = EXT_W'(1);
  localparam logic [EXT_W-1:0] BITS2_E = EXT_W'(2 * NBITS);
  localparam logic [EXT_W-1:0] DL_E    = EXT_W'(DEADLINE_CYC);

  seq_state_e       st;
  logic [CNT_W-1:0] t;
  logic             cnv_q;
  logic [CNT_W-1:0] pw_l, msb_l, per_l;
  logic [DIV_W-1:0] half_l;
  logic             ovr_l;

  logic [CNT_W-1:0] pw_in, per_in;
  logic [DIV_W-1:0] half_in;
  logic [EXT_W-1:0] blen_e, end_e;
  logic             ovr_in;
  logic             last, start;

  // clamp the configuration and judge the read window
  always_comb begin
    if (cfg_pulse_w == '0)          pw_in = ONE_C;
    else if (cfg_pulse_w > MAXHI_C) pw_in = MAXHI_C;
    else                            pw_in = cfg_pulse_w;
    per_in  = (cfg_period <= pw_in) ? (pw_in + ONE_C) : cfg_period;
    half_in = (cfg_half_div == '0) ? ONE_D : cfg_half_div;
    blen_e  = EXT_W'(half_in) * BITS2_E;
    end_e   = EXT_W'(cfg_msb_dly) + ONE_E + blen_e;
    ovr_in  = (cfg_msb_dly >= per_in)
           || (end_e > (EXT_W'(per_in) + DL_E))
           || (blen_e >= EXT_W'(per_in));
  end

  assign last  = (st == SEQ_RUN) && (t == (per_l - ONE_C));
  assign start = run && ((st == SEQ_IDLE) || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SEQ_IDLE;
      t      <= '0;
      cnv_q  <= 1'b0;
      pw_l   <= ONE_C;
      msb_l  <= '0;
      per_l  <= ONE_C + ONE_C;
      half_l <= ONE_D;
      ovr_l  <= 1'b0;
    end else if (start) begin
      st     <= SEQ_RUN;
      t      <= '0;
      cnv_q  <= 1'b1;
      pw_l   <= pw_in;
      msb_l  <= cfg_msb_dly;
      per_l  <= per_in;
      half_l <= half_in;
      ovr_l  <= ovr_in;
    end else if (st == SEQ_RUN) begin
      if (last) begin
        st    <= SEQ_IDLE;
        t     <= '0;
        cnv_q <= 1'b0;
      end else begin
        t     <= t + ONE_C;
        cnv_q <= ((t + ONE_C) < pw_l);
      end
    end
  end

  assign cnv    = cnv_q;
  assign go     = (st == SEQ_RUN) && (t == msb_l) && !ovr_l;
  assign ovr    = ovr_l;
  assign half_o = half_l;

  p_pulse_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_q |-> (t < pw_l))
    else $error("conversion pulse outlived its width");

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_IDLE) |-> !cnv_q)
    else $error("conversion pulse high while idle");

endmodule

// File: rtl/ecadc_sclk.sv
`timescale 1ns/1ps
module ecadc_sclk #(
  parameter int NBITS = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] half_in,
  output logic             sclk
);

  localparam int RW = $clog2(NBITS + 1);
  localparam logic [RW-1:0]    NB_C  = RW'(NBITS);
  localparam logic [RW-1:0]    ONE_R = RW'(1);
  localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);

  logic             busy_q, sclk_q;
  logic [DIV_W-1:0] hcnt, half_q;
  logic [RW-1:0]    rises;
  logic             tog;

  assign tog = busy_q && (hcnt == (half_q - ONE_D));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      hcnt   <= '0;
      half_q <= ONE_D;
      rises  <= '0;
    end else if (go && !busy_q) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b1;
      hcnt   <= '0;
      half_q <= half_in;
      rises  <= ONE_R;
    end else if (busy_q) begin
      if (tog) begin
        hcnt   <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q)              rises  <= rises + ONE_R;
        else if (rises == NB_C)   busy_q <= 1'b0;
      end else begin
        hcnt <= hcnt + ONE_D;
      end
    end
  end

  assign sclk = sclk_q;

  p_go_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q)
    else $error("burst requested while previous burst active");

  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q)
    else $error("read clock high outside a burst");

  p_rise_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rises <= NB_C)
    else $error("too many read clock edges");

endmodule

// File: rtl/ecadc_capture.sv
`timescale 1ns/1ps
module ecadc_capture #(
  parameter int NBITS = 16
) (
  input  logic             eclk,
  input  logic             rst_n,
  input  logic             sdata,
  output logic [NBITS-1:0] word,
  output logic             tgl
);

  localparam int CW = $clog2(NBITS);
  localparam logic [CW-1:0] LAST_C = CW'(NBITS - 1);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [NBITS-1:0] shift_q, hold_q;
  logic [CW-1:0]    cnt;
  logic             tgl_q;
  logic [NBITS-1:0] nxt;

  assign nxt = {shift_q[NBITS-2:0], sdata};

  // echo domain: first bit in ends up as the MSB
  always_ff @(posedge eclk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      hold_q  <= '0;
      cnt     <= '0;
      tgl_q   <= 1'b0;
    end else begin
      shift_q <= nxt;
      if (cnt == LAST_C) begin
        cnt    <= '0;
        hold_q <= nxt;
        tgl_q  <= ~tgl_q;
      end else begin
        cnt <= cnt + ONE_C;
      end
    end
  end

  assign word = hold_q;
  assign tgl  = tgl_q;

endmodule

// File: rtl/ecadc_xfer.sv
`timescale 1ns/1ps
module ecadc_xfer #(
  parameter int NBITS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgl_in,
  input  logic [NBITS-1:0] word_in,
  input  logic             ready,
  output logic [NBITS-1:0] data,
  output logic             valid
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   load;
  logic [NBITS-1:0]       data_q;
  logic                   valid_q;

  assign load = sync_q[SYNC_STAGES-1] ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tgl_in};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (load) begin
        data_q  <= word_in;
        valid_q <= 1'b1;
      end else if (valid_q && ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign data  = data_q;
  assign valid = valid_q;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> valid_q)
    else $error("result dropped without acceptance");

  p_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready && !load) |=> $stable(data_q))
    else $error("held result changed");

  p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ready && !load) |=> !valid_q)
    else $error("valid lingered after acceptance");

endmodule

// File: rtl/ecadc_host.sv
`timescale 1ns/1ps
module ecadc_host #(
  parameter int NBITS        = 16,
  parameter int CNT_W        = 16,
  parameter int DIV_W        = 8,
  parameter int CNV_MAX_HI   = 16,
  parameter int DEADLINE_CYC = 24,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cfg_pulse_w,
  input  logic [CNT_W-1:0] cfg_msb_dly,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [DIV_W-1:0] cfg_half_div,
  output logic             adc_cnv,
  output logic             adc_sclk,
  input  logic             adc_echo,
  input  logic             adc_sdata,
  output logic [NBITS-1:0] res_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             err_overrun
);

  logic             go;
  logic [DIV_W-1:0] half;
  logic [NBITS-1:0] word;
  logic             tgl;

  ecadc_seq #(
    .NBITS(NBITS), .CNT_W(CNT_W), .DIV_W(DIV_W),
    .CNV_MAX_HI(CNV_MAX_HI), .DEADLINE_CYC(DEADLINE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_pulse_w(cfg_pulse_w), .cfg_msb_dly(cfg_msb_dly),
    .cfg_period(cfg_period), .cfg_half_div(cfg_half_div),
    .cnv(adc_cnv), .go(go), .ovr(err_overrun), .half_o(half)
  );

  ecadc_sclk #(.NBITS(NBITS), .DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .go(go), .half_in(half), .sclk(adc_sclk)
  );

  ecadc_capture #(.NBITS(NBITS)) u_cap (
    .eclk(adc_echo), .rst_n(rst_n), .sdata(adc_sdata), .word(word), .tgl(tgl)
  );

  ecadc_xfer #(.NBITS(NBITS), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk(clk), .rst_n(rst_n), .tgl_in(tgl), .word_in(word),
    .ready(res_ready), .data(res_data), .valid(res_valid)
  );

endmodule

// File: tb/tb_ecadc_host.sv
`timescale 1ns/1ps
module tb_ecadc_host;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        run = 1'b0;
  logic [15:0] cfg_pulse_w = '0, cfg_msb_dly = '0, cfg_period = '0;
  logic [7:0]  cfg_half_div = '0;
  logic        adc_cnv, adc_sclk;
  logic        adc_echo = 1'b0, adc_sdata = 1'b0;
  logic [15:0] res_data;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        err_overrun;

  always #4 clk = ~clk;

  ecadc_host dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_pulse_w(cfg_pulse_w), .cfg_msb_dly(cfg_msb_dly),
    .cfg_period(cfg_period), .cfg_half_div(cfg_half_div),
    .adc_cnv(adc_cnv), .adc_sclk(adc_sclk),
    .adc_echo(adc_echo), .adc_sdata(adc_sdata),
    .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready),
    .err_overrun(err_overrun)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sample_of(input int i);
    return 16'((32'hA5C3 ^ (i * 32'h3B1D)) + i);
  endfunction

  // expectations set by the driver
  int exp_pw = 1, exp_per = 2, exp_msb = 0, exp_half = 1;
  bit cur_ovr = 0;
  logic [15:0] exp_q[$];

  // converter model: echo delay and MSB-first data on echo falling edges
  logic echo_v;
  always @(adc_sclk) begin
    echo_v = adc_sclk;
    #2;
    adc_echo = echo_v;
  end

  int conv_idx = 0;
  int mbit = 0;
  logic [15:0] cur_w = '0, pend_w = '0;
  bit pend_v = 0;

  always @(posedge adc_cnv) begin
    logic [15:0] s;
    s = sample_of(conv_idx);
    conv_idx++;
    if (!cur_ovr) exp_q.push_back(s);  // driver side of the scoreboard
    if (mbit == 0) begin
      cur_w = s;
      adc_sdata = s[15];
    end else begin
      pend_w = s;
      pend_v = 1;
    end
  end

  always @(negedge adc_echo) begin
    mbit++;
    if (mbit == 16) begin
      mbit = 0;
      if (pend_v) begin
        cur_w = pend_w;
        pend_v = 0;
        adc_sdata = cur_w[15];
      end else begin
        adc_sdata = 1'b0;
      end
    end else begin
      adc_sdata = cur_w[15 - mbit];
    end
  end

  // monitor: timing of pins and scoreboard pops
  int cyc = 0, last_rise = 0, hi_len = 0;
  bit have_rise = 0;
  logic cnv_d = 0, sclk_d = 0;
  int low_run = 1000, high_run = 0, burst_cnt = 0, total_rises = 0, vcount = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (adc_cnv && !cnv_d) begin
        if (have_rise) chk((cyc - last_rise) == exp_per, "R3 pulse spacing", cyc - last_rise, exp_per);
        have_rise = 1;
        last_rise = cyc;
        hi_len = 0;
      end
      if (adc_cnv) hi_len++;
      if (!adc_cnv && cnv_d) chk(hi_len == exp_pw, "R2 pulse width", hi_len, exp_pw);
      if (adc_sclk && !sclk_d) begin
        total_rises++;
        if (low_run != exp_half) begin
          if (burst_cnt != 0) chk(burst_cnt == 16, "R5 edges per burst", burst_cnt, 16);
          burst_cnt = 1;
          chk((cyc - last_rise) == exp_msb + 1, "R4 burst start", cyc - last_rise, exp_msb + 1);
        end else begin
          burst_cnt++;
        end
        high_run = 0;
      end
      if (adc_sclk) high_run++;
      if (!adc_sclk && sclk_d) begin
        chk(high_run == exp_half, "R5 high phase", high_run, exp_half);
        low_run = 0;
      end
      if (!adc_sclk) low_run++;
      if (res_valid && res_ready) begin
        vcount++;
        if (exp_q.size() == 0) chk(0, "R6 unexpected result", res_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(res_data == e, "R6 result word", res_data, e);
        end
      end
      cnv_d = adc_cnv;
      sclk_d = adc_sclk;
    end
  end

  task automatic run_phase(input int pw, input int m, input int p, input int h,
                           input int n, input bit drain);
    int pw_e, per_e, h_e, bl, base, r0, v0;
    bit ovr;
    pw_e  = (pw == 0) ? 1 : ((pw > 16) ? 16 : pw);
    per_e = (p <= pw_e) ? pw_e + 1 : p;
    h_e   = (h == 0) ? 1 : h;
    bl    = 32 * h_e;
    ovr   = (m >= per_e) || (m + 1 + bl > per_e + 24) || (bl >= per_e);
    @(posedge clk); #1;
    cfg_pulse_w = 16'(pw); cfg_msb_dly = 16'(m); cfg_period = 16'(p); cfg_half_div = 8'(h);
    exp_pw = pw_e; exp_per = per_e; exp_msb = m; exp_half = h_e; cur_ovr = ovr;
    have_rise = 0; burst_cnt = 0;
    base = conv_idx; r0 = total_rises; v0 = vcount;
    run = 1'b1;
    while (conv_idx < base + 1) @(negedge clk);
    @(negedge clk);
    chk(err_overrun == ovr, "R8 overrun flag", err_overrun, ovr);
    while (conv_idx < base + n) @(negedge clk);
    @(posedge clk); #1;
    run = 1'b0;
    repeat (per_e + m + bl + 80) @(negedge clk);
    chk(conv_idx - base == n, "R3 pulses after run drop", conv_idx - base, n);
    chk(!adc_sclk, "R5 clock idles low", adc_sclk, 0);
    if (ovr) begin
      chk(total_rises == r0, "R8 no burst when overrun", total_rises - r0, 0);
      chk(vcount == v0, "R8 no result when overrun", vcount - v0, 0);
    end else begin
      chk(total_rises - r0 == 16 * n, "R5 total edges", total_rises - r0, 16 * n);
      chk(burst_cnt == 16, "R5 last burst edges", burst_cnt, 16);
    end
    burst_cnt = 0;
    if (drain) chk(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit busy_seen;
    #1 rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    busy_seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (adc_cnv || adc_sclk || res_valid || err_overrun) busy_seen = 1;
    end
    chk(!busy_seen, "R1 quiet before run", busy_seen, 0);
    chk(!adc_cnv && !adc_sclk, "R1 converter pins low", {adc_cnv, adc_sclk}, 0);
    chk(!res_valid && !err_overrun, "R1 result and flag low", {res_valid, err_overrun}, 0);

    run_phase(3, 10, 60, 1, 4, 1);     // R6 first result after reset
    run_phase(2, 20, 40, 1, 4, 1);     // R8 burst past next pulse, within deadline
    run_phase(1, 5, 80, 2, 3, 1);      // R5 slower read clock
    run_phase(40, 20, 100, 0, 2, 1);   // R2 clamp, R5 zero divisor
    run_phase(0, 12, 60, 1, 2, 1);     // R2 zero width
    run_phase(2, 55, 60, 1, 2, 1);     // R8 deadline overrun
    run_phase(10, 2, 5, 1, 3, 1);      // R3 period raised above width, overrun
    run_phase(3, 10, 60, 1, 2, 1);     // R8 flag clears

    // R7 back-pressure: two words while not ready, the newer one wins
    @(posedge clk); #1;
    res_ready = 1'b0;
    run_phase(3, 10, 60, 1, 2, 0);
    chk(res_valid, "R7 held while not ready", res_valid, 1);
    chk(exp_q.size() == 2, "R7 two words produced", exp_q.size(), 2);
    if (exp_q.size() == 2) begin
      chk(res_data == exp_q[1], "R7 newest word kept", res_data, exp_q[1]);
      void'(exp_q.pop_front());
    end
    @(posedge clk); #1;
    res_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!res_valid, "R7 valid drops after accept", res_valid, 0);
    chk(exp_q.size() == 0, "R7 held word delivered", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule